// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block is a small pool of reservation stations for an out-of-order scheduler that renames registers into reorder-buffer slots. The issue stage places an instruction into a free station. Each source operand arrives either as a value or as the reorder-buffer index of the instruction that will produce it. Stations snoop one common data bus (CDB). When a broadcast tag matches a pending operand, the station copies the broadcast value. A station whose operands are all values asks for the shared ALU. The lowest-numbered eligible station gets the ALU when an external arbiter grants it.

The ALU result stays inside the station until the bus arbiter grants the pool a broadcast slot. The station is released only in that grant cycle, so it stays occupied while it waits for the bus. A store computes its address (base plus immediate) once the base is known, and it does not need its data value to execute. It broadcasts only once the data value has also arrived. That broadcast carries the address, the data value and a store marker, so that the reorder buffer can perform the memory write at commit. A flush input discards every station.

Top module: `rs_pool`

## Requirements
- R1: After reset no station is occupied: `stall`, `ex_req`, `cdb_req` and `cdb_out_valid` are all low.
- R2: A request on `alloc_valid` is accepted only while `stall` is low, and it fills the lowest-numbered free station. A request made while `stall` is high is dropped and never produces a broadcast.
- R3: An operand given as a tag is filled from the first `cdb_in` broadcast whose tag equals it. Broadcasts with other tags have no effect. A station does not raise `ex_req` until its needed operands are all values.
- R4: If `cdb_in` carries the awaited tag in the same cycle as the allocation, that value is captured.
- R5: Operation codes are 0 add a+b, 1 subtract a-b, 2 AND, 3 OR, 4 XOR, 5 shift left a by b[log2(DATA_W)-1:0], 6 unsigned a<b giving 1 or 0, and 7 store, which gives address a+imm.
- R6: Among the stations that are ready to execute, the lowest-numbered one executes on an `ex_req`/`ex_gnt` cycle. Exactly one station executes per granted cycle.
- R7: A store executes as soon as its base is a value. It keeps `cdb_req` low until its data operand is a value. It then broadcasts `cdb_out_data` = address, `cdb_out_sdata` = data and `cdb_out_store` = 1.
- R8: A result is broadcast only in a cycle where `cdb_req` and `cdb_gnt` are both high. In that cycle `cdb_out_valid` is high and the station is freed. Until then the station holds its result and keeps requesting. When several results are waiting, the lowest-numbered station goes first.
- R9: `stall` is high exactly when every station is occupied.
- R10: `flush` empties every station in one cycle. Discarded work never broadcasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all stations |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 3 | Operation code (R5) |
| alloc_dest | input | TAG_W | Reorder-buffer index of this instruction |
| alloc_imm | input | DATA_W | Store address offset |
| alloc_a_ready | input | 1 | Operand A is a value |
| alloc_a_value | input | DATA_W | Operand A value |
| alloc_a_tag | input | TAG_W | Operand A producer tag |
| alloc_b_ready | input | 1 | Operand B is a value |
| alloc_b_value | input | DATA_W | Operand B value (store data for stores) |
| alloc_b_tag | input | TAG_W | Operand B producer tag |
| stall | output | 1 | No free station |
| cdb_in_valid | input | 1 | Bus broadcast valid |
| cdb_in_tag | input | TAG_W | Bus broadcast tag |
| cdb_in_data | input | DATA_W | Bus broadcast value |
| ex_req | output | 1 | A station is ready to execute |
| ex_gnt | input | 1 | ALU granted this cycle |
| cdb_req | output | 1 | A result waits for the bus |
| cdb_gnt | input | 1 | Bus granted this cycle |
| cdb_out_valid | output | 1 | Broadcast happening this cycle |
| cdb_out_tag | output | TAG_W | Destination tag of the broadcast |
| cdb_out_data | output | DATA_W | Result, or store address |
| cdb_out_store | output | 1 | Broadcast belongs to a store |
| cdb_out_sdata | output | DATA_W | Store data value |

## Verification
If a station misses a wakeup, the symptom at the ports is that `ex_req` stays low after the matching broadcast. The expected result then never appears on `cdb_out`, and the bench reports it at the end of the run as an outstanding scoreboard item. A wrong capture, such as a stale value or a value taken from a mismatched tag, shows up in the broadcast one to two cycles after execute as a data mismatch against the scoreboard. Priority or release faults change the order of broadcast tags, or leave `stall` high a cycle after a broadcast from a full pool. Both are visible in the cycle of the broadcast.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_SLL   = 3'd5,
    OP_SLTU  = 3'd6,
    OP_STORE = 3'd7
  } rs_op_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } rs_state_e;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index priority picker: one-hot grant plus any-request flag.
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/rs_alu.sv
module rs_alu
  import rsp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SHW = $clog2(DATA_W);

  always_comb begin
    case (rs_op_e'(op_i))
      OP_ADD:   res_o = a_i + b_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SLL:   res_o = a_i << b_i[SHW-1:0];
      OP_SLTU:  res_o = {{(DATA_W-1){1'b0}}, (a_i < b_i)};
      OP_STORE: res_o = a_i + imm_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/rs_entry.sv
// One reservation station: operand tracking, bus snooping, result hold.
module rs_entry
  import rsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [2:0]        op_i,
  input  logic [TAG_W-1:0]  dest_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              ardy_i,
  input  logic [DATA_W-1:0] aval_i,
  input  logic [TAG_W-1:0]  atag_i,
  input  logic              brdy_i,
  input  logic [DATA_W-1:0] bval_i,
  input  logic [TAG_W-1:0]  btag_i,
  input  logic              cdb_v_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              exec_i,
  input  logic [DATA_W-1:0] exec_res_i,
  input  logic              bcast_i,
  output logic              busy_o,
  output logic              ex_rdy_o,
  output logic              bc_rdy_o,
  output logic [2:0]        op_o,
  output logic [TAG_W-1:0]  dest_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] res_o,
  output logic              store_o
);
  rs_state_e         state_q, state_d;
  logic              ardy_q, ardy_d, brdy_q, brdy_d;
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d, res_q, imm_q;
  logic [TAG_W-1:0]  atag_q, btag_q, dest_q;
  logic [2:0]        op_q;

  logic snoop_a, snoop_b, byp_a, byp_b;
  logic en_a, en_b, en_res, en_hdr;

  // Capture from the bus while occupied
  assign snoop_a = (state_q != ST_FREE) && !ardy_q && cdb_v_i && (cdb_tag_i == atag_q);
  assign snoop_b = (state_q != ST_FREE) && !brdy_q && cdb_v_i && (cdb_tag_i == btag_q);
  // Capture from the bus in the allocation cycle
  assign byp_a   = !ardy_i && cdb_v_i && (cdb_tag_i == atag_i);
  assign byp_b   = !brdy_i && cdb_v_i && (cdb_tag_i == btag_i);

  assign en_hdr = alloc_i;
  assign en_a   = alloc_i | snoop_a;
  assign en_b   = alloc_i | snoop_b;
  assign en_res = exec_i;

  always_comb begin
    state_d = state_q;
    ardy_d  = ardy_q;
    brdy_d  = brdy_q;
    a_d     = a_q;
    b_d     = b_q;
    if (flush_i) begin
      state_d = ST_FREE;
    end else if (alloc_i) begin
      state_d = ST_WAIT;
      ardy_d  = ardy_i | byp_a;
      brdy_d  = brdy_i | byp_b;
      a_d     = ardy_i ? aval_i : cdb_data_i;
      b_d     = brdy_i ? bval_i : cdb_data_i;
    end else begin
      if (snoop_a) begin
        ardy_d = 1'b1;
        a_d    = cdb_data_i;
      end
      if (snoop_b) begin
        brdy_d = 1'b1;
        b_d    = cdb_data_i;
      end
      if (exec_i)  state_d = ST_DONE;
      if (bcast_i) state_d = ST_FREE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      ardy_q  <= 1'b0;
      brdy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ardy_q  <= ardy_d;
      brdy_q  <= brdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en_hdr) begin
      op_q   <= op_i;
      dest_q <= dest_i;
      imm_q  <= imm_i;
      atag_q <= atag_i;
      btag_q <= btag_i;
    end
    if (en_a)   a_q   <= a_d;
    if (en_b)   b_q   <= b_d;
    if (en_res) res_q <= exec_res_i;
  end

  assign store_o  = (rs_op_e'(op_q) == OP_STORE);
  assign busy_o   = (state_q != ST_FREE);
  assign ex_rdy_o = (state_q == ST_WAIT) && ardy_q && (store_o || brdy_q);
  assign bc_rdy_o = (state_q == ST_DONE) && (!store_o || brdy_q);
  assign op_o     = op_q;
  assign dest_o   = dest_q;
  assign imm_o    = imm_q;
  assign a_o      = a_q;
  assign b_o      = b_q;
  assign res_o    = res_q;
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rsp_pkg::*;
#(
  parameter int NUM_RS = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [2:0]        alloc_op,
  input  logic [TAG_W-1:0]  alloc_dest,
  input  logic [DATA_W-1:0] alloc_imm,
  input  logic              alloc_a_ready,
  input  logic [DATA_W-1:0] alloc_a_value,
  input  logic [TAG_W-1:0]  alloc_a_tag,
  input  logic              alloc_b_ready,
  input  logic [DATA_W-1:0] alloc_b_value,
  input  logic [TAG_W-1:0]  alloc_b_tag,
  output logic              stall,
  input  logic              cdb_in_valid,
  input  logic [TAG_W-1:0]  cdb_in_tag,
  input  logic [DATA_W-1:0] cdb_in_data,
  output logic              ex_req,
  input  logic              ex_gnt,
  output logic              cdb_req,
  input  logic              cdb_gnt,
  output logic              cdb_out_valid,
  output logic [TAG_W-1:0]  cdb_out_tag,
  output logic [DATA_W-1:0] cdb_out_data,
  output logic              cdb_out_store,
  output logic [DATA_W-1:0] cdb_out_sdata
);
  logic [NUM_RS-1:0] busy_v, free_v, ex_rdy_v, bc_rdy_v;
  logic [NUM_RS-1:0] alloc_sel, ex_sel, bc_sel;
  logic              free_any, alloc_fire, exec_fire, bcast_fire;

  logic [2:0]        e_op   [NUM_RS];
  logic [TAG_W-1:0]  e_dest [NUM_RS];
  logic [DATA_W-1:0] e_imm  [NUM_RS];
  logic [DATA_W-1:0] e_a    [NUM_RS];
  logic [DATA_W-1:0] e_b    [NUM_RS];
  logic [DATA_W-1:0] e_res  [NUM_RS];
  logic              e_st   [NUM_RS];

  logic [2:0]        x_op;
  logic [DATA_W-1:0] x_a, x_b, x_imm, x_res;

  assign free_v = ~busy_v;

  rs_pick #(.N(NUM_RS)) u_pick_alloc (.req_i(free_v),   .gnt_o(alloc_sel), .any_o(free_any));
  rs_pick #(.N(NUM_RS)) u_pick_exec  (.req_i(ex_rdy_v), .gnt_o(ex_sel),    .any_o(ex_req));
  rs_pick #(.N(NUM_RS)) u_pick_bcast (.req_i(bc_rdy_v), .gnt_o(bc_sel),    .any_o(cdb_req));

  assign stall      = ~free_any;
  assign alloc_fire = alloc_valid & free_any & ~flush;
  assign exec_fire  = ex_req & ex_gnt & ~flush;
  assign bcast_fire = cdb_req & cdb_gnt & ~flush;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .alloc_i    (alloc_fire & alloc_sel[i]),
      .op_i       (alloc_op),
      .dest_i     (alloc_dest),
      .imm_i      (alloc_imm),
      .ardy_i     (alloc_a_ready),
      .aval_i     (alloc_a_value),
      .atag_i     (alloc_a_tag),
      .brdy_i     (alloc_b_ready),
      .bval_i     (alloc_b_value),
      .btag_i     (alloc_b_tag),
      .cdb_v_i    (cdb_in_valid),
      .cdb_tag_i  (cdb_in_tag),
      .cdb_data_i (cdb_in_data),
      .exec_i     (exec_fire & ex_sel[i]),
      .exec_res_i (x_res),
      .bcast_i    (bcast_fire & bc_sel[i]),
      .busy_o     (busy_v[i]),
      .ex_rdy_o   (ex_rdy_v[i]),
      .bc_rdy_o   (bc_rdy_v[i]),
      .op_o       (e_op[i]),
      .dest_o     (e_dest[i]),
      .imm_o      (e_imm[i]),
      .a_o        (e_a[i]),
      .b_o        (e_b[i]),
      .res_o      (e_res[i]),
      .store_o    (e_st[i])
    );
  end

  // Operand mux toward the ALU (one-hot select)
  always_comb begin
    x_op  = '0;
    x_a   = '0;
    x_b   = '0;
    x_imm = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (ex_sel[i]) begin
        x_op  = x_op  | e_op[i];
        x_a   = x_a   | e_a[i];
        x_b   = x_b   | e_b[i];
        x_imm = x_imm | e_imm[i];
      end
    end
  end

  rs_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (x_op),
    .a_i   (x_a),
    .b_i   (x_b),
    .imm_i (x_imm),
    .res_o (x_res)
  );

  // Result mux toward the bus (one-hot select)
  always_comb begin
    cdb_out_tag   = '0;
    cdb_out_data  = '0;
    cdb_out_sdata = '0;
    cdb_out_store = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (bc_sel[i]) begin
        cdb_out_tag   = cdb_out_tag   | e_dest[i];
        cdb_out_data  = cdb_out_data  | e_res[i];
        cdb_out_sdata = cdb_out_sdata | e_b[i];
        cdb_out_store = cdb_out_store | e_st[i];
      end
    end
  end

  assign cdb_out_valid = bcast_fire;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic alloc_valid,
  input logic stall,
  input logic ex_req,
  input logic ex_gnt,
  input logic cdb_req,
  input logic cdb_gnt,
  input logic cdb_out_valid
);
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!stall && !ex_req && !cdb_req));

  // R8
  bcast_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_out_valid && stall && !flush) |=> !stall);

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_req && !cdb_gnt && !flush) |=> cdb_req);

  // R6
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_req && !ex_gnt && !flush) |=> ex_req);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cdb_out_valid && !flush) |=> stall);

  // R2
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && stall && !flush && !cdb_out_valid) |=> stall);
endmodule

bind rs_pool rs_pool_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .alloc_valid   (alloc_valid),
  .stall         (stall),
  .ex_req        (ex_req),
  .ex_gnt        (ex_gnt),
  .cdb_req       (cdb_req),
  .cdb_gnt       (cdb_gnt),
  .cdb_out_valid (cdb_out_valid)
);

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
  localparam int NRS = 4;
  localparam int DW  = 32;
  localparam int TW  = 4;

  logic          clk, rst_n, flush;
  logic          alloc_valid;
  logic [2:0]    alloc_op;
  logic [TW-1:0] alloc_dest, alloc_a_tag, alloc_b_tag;
  logic [DW-1:0] alloc_imm, alloc_a_value, alloc_b_value;
  logic          alloc_a_ready, alloc_b_ready, stall;
  logic          cdb_in_valid;
  logic [TW-1:0] cdb_in_tag;
  logic [DW-1:0] cdb_in_data;
  logic          ex_req, ex_gnt, cdb_req, cdb_gnt, cdb_out_valid, cdb_out_store;
  logic [TW-1:0] cdb_out_tag;
  logic [DW-1:0] cdb_out_data, cdb_out_sdata;

  rs_pool #(.NUM_RS(NRS), .DATA_W(DW), .TAG_W(TW)) u_rs_pool (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
    logic [DW-1:0] sdata;
    logic          st;
  } exp_t;

  exp_t          exp_q[$];
  logic [TW-1:0] seen_q[$];
  int            total = 0;
  int            bad   = 0;
  int            cyc   = 0;

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [2:0] op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b, input logic [DW-1:0] imm);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return (a < b) ? 1 : 0;
      default: return a + imm;
    endcase
  endfunction

  // Driver: allocate one station and record the expected broadcast
  task automatic alloc(input logic [2:0] op, input logic [TW-1:0] dest, input logic [DW-1:0] imm,
                       input logic ar, input logic [DW-1:0] av, input logic [TW-1:0] at,
                       input logic br, input logic [DW-1:0] bv, input logic [TW-1:0] bt,
                       input logic push);
    exp_t e;
    while (stall) begin @(posedge clk); #1; end
    alloc_valid   = 1'b1;
    alloc_op      = op;
    alloc_dest    = dest;
    alloc_imm     = imm;
    alloc_a_ready = ar;
    alloc_a_value = ar ? av : 32'hDEAD_BEEF;
    alloc_a_tag   = at;
    alloc_b_ready = br;
    alloc_b_value = br ? bv : 32'hBAD0_BAD0;
    alloc_b_tag   = bt;
    if (push) begin
      e.tag = dest; e.data = model(op, av, bv, imm); e.sdata = bv; e.st = (op == 3'd7);
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic bus_send(input logic [TW-1:0] t, input logic [DW-1:0] d);
    cdb_in_valid = 1'b1; cdb_in_tag = t; cdb_in_data = d;
    @(posedge clk); #1;
    cdb_in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Monitor: pop and compare each broadcast
  always @(negedge clk) begin
    if (rst_n && cdb_out_valid) begin
      int idx;
      idx = -1;
      foreach (exp_q[k]) if (idx < 0 && exp_q[k].tag == cdb_out_tag) idx = k;
      seen_q.push_back(cdb_out_tag);
      if (idx < 0) begin
        chk(1'b0, "R2/R10 unexpected broadcast tag", {28'd0, cdb_out_tag}, '0);
      end else begin
        chk(cdb_out_data == exp_q[idx].data, "R5 result data", cdb_out_data, exp_q[idx].data);
        chk(cdb_out_store == exp_q[idx].st, "R7 store marker", {31'd0, cdb_out_store}, {31'd0, exp_q[idx].st});
        if (exp_q[idx].st)
          chk(cdb_out_sdata == exp_q[idx].sdata, "R7 store data", cdb_out_sdata, exp_q[idx].sdata);
        exp_q.delete(idx);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; alloc_valid = 1'b0; alloc_op = '0; alloc_dest = '0;
    alloc_imm = '0; alloc_a_ready = 1'b0; alloc_a_value = '0; alloc_a_tag = '0;
    alloc_b_ready = 1'b0; alloc_b_value = '0; alloc_b_tag = '0;
    cdb_in_valid = 1'b0; cdb_in_tag = '0; cdb_in_data = '0;
    ex_gnt = 1'b1; cdb_gnt = 1'b1;
    idle(3);
    // R1 reset state
    chk(!stall && !ex_req && !cdb_req && !cdb_out_valid, "R1 idle after reset",
        {28'd0, stall, ex_req, cdb_req, cdb_out_valid}, '0);
    rst_n = 1'b1;
    idle(2);

    // R5 every operation with ready operands
    alloc(3'd0, 4'd1, 0, 1, 32'h8000_0003, 0, 1, 32'h7FFF_FFFF, 0, 1);
    alloc(3'd1, 4'd2, 0, 1, 32'd5, 0, 1, 32'd9, 0, 1);
    alloc(3'd2, 4'd3, 0, 1, 32'hF0F0_1234, 0, 1, 32'h0FF0_FF00, 0, 1);
    alloc(3'd3, 4'd4, 0, 1, 32'hF000_0001, 0, 1, 32'h0000_0F10, 0, 1);
    alloc(3'd4, 4'd5, 0, 1, 32'hAAAA_5555, 0, 1, 32'hFFFF_0000, 0, 1);
    alloc(3'd5, 4'd6, 0, 1, 32'h0000_0013, 0, 1, 32'h0000_0024, 0, 1);
    alloc(3'd6, 4'd7, 0, 1, 32'd1, 0, 1, 32'hFFFF_FFFF, 0, 1);
    alloc(3'd6, 4'd8, 0, 1, 32'hFFFF_FFFF, 0, 1, 32'd1, 0, 1);
    idle(5);
    chk(exp_q.size() == 0, "R5 all results broadcast", exp_q.size(), 0);

    // R3 wait on a tag, ignore a mismatched one, wake on the match
    alloc(3'd0, 4'd2, 0, 0, 32'd100, 4'd9, 1, 32'd23, 0, 1);
    idle(3);
    chk(!ex_req, "R3 no request while waiting", {31'd0, ex_req}, 0);
    bus_send(4'd8, 32'd555);
    chk(!ex_req && !cdb_req, "R3 mismatched tag ignored", {30'd0, ex_req, cdb_req}, 0);
    bus_send(4'd9, 32'd100);
    idle(4);
    chk(exp_q.size() == 0, "R3 wakeup produced result", exp_q.size(), 0);

    // R3 both operands waiting, delivered in separate cycles
    alloc(3'd1, 4'd3, 0, 0, 32'd1000, 4'd10, 0, 32'd1, 4'd11, 1);
    bus_send(4'd11, 32'd1);
    idle(2);
    chk(!ex_req, "R3 still waiting for A", {31'd0, ex_req}, 0);
    bus_send(4'd10, 32'd1000);
    idle(4);
    chk(exp_q.size() == 0, "R3 two-operand wakeup", exp_q.size(), 0);

    // R4 broadcast in the allocation cycle is captured
    cdb_in_valid = 1'b1; cdb_in_tag = 4'd5; cdb_in_data = 32'h0000_4000;
    alloc(3'd3, 4'd4, 0, 0, 32'h0000_4000, 4'd5, 1, 32'h0000_0007, 0, 1);
    cdb_in_valid = 1'b0;
    idle(4);
    chk(exp_q.size() == 0, "R4 same-cycle capture", exp_q.size(), 0);

    // R7 store: address early, broadcast only when data arrives
    alloc(3'd7, 4'd6, 32'd16, 1, 32'h0000_1000, 0, 0, 32'h0000_CAFE, 4'd7, 1);
    idle(4);
    chk(!ex_req && !cdb_req, "R7 store address done, no broadcast yet", {30'd0, ex_req, cdb_req}, 0);
    bus_send(4'd7, 32'h0000_CAFE);
    idle(3);
    chk(exp_q.size() == 0, "R7 store broadcast", exp_q.size(), 0);

    // R8/R9/R2 fill with the bus blocked, drop a request, drain in order
    cdb_gnt = 1'b0;
    seen_q.delete();
    alloc(3'd0, 4'd1, 0, 1, 32'd1, 0, 1, 32'd1, 0, 1);
    alloc(3'd0, 4'd2, 0, 1, 32'd2, 0, 1, 32'd2, 0, 1);
    alloc(3'd0, 4'd3, 0, 1, 32'd3, 0, 1, 32'd3, 0, 1);
    alloc(3'd0, 4'd4, 0, 1, 32'd4, 0, 1, 32'd4, 0, 1);
    idle(5);
    chk(stall, "R9 stall when full", {31'd0, stall}, 1);
    chk(cdb_req && seen_q.size() == 0, "R8 results held without grant", seen_q.size(), 0);
    alloc_valid = 1'b1; alloc_op = 3'd0; alloc_dest = 4'd12;
    alloc_a_ready = 1'b1; alloc_b_ready = 1'b1;
    idle(2);
    alloc_valid = 1'b0;
    cdb_gnt = 1'b1;
    idle(6);
    chk(seen_q.size() == 4, "R8 drained count", seen_q.size(), 4);
    if (seen_q.size() == 4)
      for (int k = 0; k < 4; k++)
        chk(seen_q[k] == 4'(k + 1), "R8 lowest station first / R2 placement", {28'd0, seen_q[k]}, k + 1);
    chk(!stall, "R9 stall clears after drain", {31'd0, stall}, 0);

    // R6 lowest-index station executes first
    seen_q.delete();
    ex_gnt = 1'b0;
    alloc(3'd0, 4'd11, 0, 1, 32'd7, 0, 1, 32'd8, 0, 1);
    alloc(3'd1, 4'd12, 0, 1, 32'd7, 0, 1, 32'd8, 0, 1);
    idle(1);
    chk(ex_req && !cdb_req, "R6 requests before grant", {30'd0, ex_req, cdb_req}, 2);
    ex_gnt = 1'b1;
    @(posedge clk); #1;
    ex_gnt = 1'b0;
    idle(3);
    chk(seen_q.size() == 1 && seen_q[0] == 4'd11, "R6 first executed is lowest station",
        seen_q.size() > 0 ? {28'd0, seen_q[0]} : 32'hFFFF_FFFF, 11);
    ex_gnt = 1'b1;
    idle(4);
    chk(seen_q.size() == 2 && seen_q[1] == 4'd12, "R6 second station follows",
        seen_q.size() > 1 ? {28'd0, seen_q[1]} : 32'hFFFF_FFFF, 12);

    // R10 flush discards waiting stations
    seen_q.delete();
    for (int k = 0; k < 4; k++) alloc(3'd0, 4'(k + 1), 0, 0, 32'd0, 4'd14, 1, 32'd1, 0, 0);
    chk(stall, "R10 pool full before flush", {31'd0, stall}, 1);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    chk(!stall && !ex_req && !cdb_req, "R10 empty after flush", {29'd0, stall, ex_req, cdb_req}, 0);
    bus_send(4'd14, 32'd77);
    idle(4);
    chk(seen_q.size() == 0, "R10 flushed work silent", seen_q.size(), 0);
    alloc(3'd4, 4'd9, 0, 1, 32'h1234, 0, 1, 32'h00FF, 0, 1);
    idle(4);
    chk(exp_q.size() == 0, "R10 allocation after flush", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule